// File: doc/BRIEF.md
# Scratch Memory Pointer Addressing Unit

This block produces word addresses for a small scratch memory that sits next to a multi-threaded packet core. Every thread context keeps two address pointers of its own. Software loads a pointer through a dedicated write port. An access names a context, picks one of its two pointers and gives an addressing mode. The pointer can be used as is, or it can be stepped forward or backward by one word once the access has used it. When a step takes a pointer past either end of the memory, the pointer wraps around at the memory depth. It does not wrap at the next power of two.

The unit also contains the memory array. A write access stores its data in the same clock edge that samples the request. A read access is carried through a fixed-depth register pipeline, so a new read can start in every cycle and each result appears a fixed number of cycles later. A pointer load and an access to the same pointer in the same cycle are resolved in favour of the load. The access then uses the loaded value, and any step is applied on top of that value.

Top module: `lm_addr_unit`

## Requirements
- R1: After synchronous reset every pointer of every context reads as 0 and `rd_valid` is low.
- R2: A pointer load stores `ptr_wr_val` into the pointer chosen by `ptr_wr_ctx`/`ptr_wr_sel`, and leaves every other pointer unchanged. A value at or above DEPTH is stored minus DEPTH (700 is stored as 60 with DEPTH 640). The address presented on `acc_addr` is always below DEPTH.
- R3: Mode code 00 (plain), and the spare code 11, present the selected pointer on `acc_addr` and leave the pointer unchanged.
- R4: Mode code 01 (post-increment) presents the old pointer value, and the pointer then becomes old+1. DEPTH-1 steps to 0.
- R5: Mode code 10 (post-decrement) presents the old pointer value, and the pointer then becomes old-1. 0 steps to DEPTH-1.
- R6: When a load and an access hit the same pointer in one cycle, `acc_addr` shows the loaded (folded) value, and the mode's step is applied to that value.
- R7: An access to the same pointer in the very next cycle already sees the stepped value.
- R8: An access with `acc_we` high stores `acc_wdata` at `acc_addr` on that clock edge. A read issued in the next cycle returns the new word.
- R9: A read issued in cycle c shows `rd_valid` high with its word on `rd_data` in cycle c+RD_LAT, and not earlier. Back-to-back reads return their words in order, one per cycle.
- R10: With `acc_en` low, no pointer steps, nothing is written to the array and no read result is produced, whatever the mode, select and write-enable inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr_en | input | 1 | Pointer load strobe |
| ptr_wr_ctx | input | CTX_W (3) | Context whose pointer is loaded |
| ptr_wr_sel | input | 1 | Which of the two pointers is loaded |
| ptr_wr_val | input | AW (10) | Value to load |
| acc_en | input | 1 | Access request |
| acc_ctx | input | CTX_W (3) | Context issuing the access |
| acc_sel | input | 1 | Pointer used by the access |
| acc_mode | input | 2 | 00 plain, 01 post-increment, 10 post-decrement, 11 plain |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_wdata | input | DW (32) | Write data |
| acc_addr | output | AW (10) | Word address used by the current access |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW (32) | Read result |

## Verification
The bench uses the default parameters: eight contexts, a depth of 640 words, 32-bit data and a read latency of three. A depth of 640 is not a power of two. This puts the wrap from 639 to 0 and from 0 to 639 in reach, and a raw 10-bit step would get both wrong. It also puts the folding of loaded values between 640 and 1023 in reach. A latency of three leaves two cycles in which an early result can be caught, and lets three back-to-back reads overlap inside the pipeline.

// File: rtl/lmau_pkg.sv
package lmau_pkg;

    typedef enum logic [1:0] {
        LM_PLAIN   = 2'b00,
        LM_POSTINC = 2'b01,
        LM_POSTDEC = 2'b10,
        LM_SPARE   = 2'b11
    } lm_mode_e;

    // Reduce a loaded value into the range [0, depth).
    // Valid whenever the value is below 2*depth.
    function automatic int unsigned lm_fold(int unsigned v, int unsigned depth);
        return (v >= depth) ? (v - depth) : v;
    endfunction

    // Value a pointer takes after an access in the given mode.
    function automatic int unsigned lm_step(int unsigned a, lm_mode_e m,
                                            int unsigned depth);
        int unsigned r;
        case (m)
            LM_POSTINC: r = (a + 1 == depth) ? 0 : a + 1;
            LM_POSTDEC: r = (a == 0) ? depth - 1 : a - 1;
            default:    r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lm_ptr_file.sv
module lm_ptr_file
    import lmau_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int DEPTH   = 640,
    parameter int AW      = $clog2(DEPTH),
    parameter int CTX_W   = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic             wr_sel,
    input  logic [AW-1:0]    wr_val,
    input  logic             acc_en,
    input  logic [CTX_W-1:0] acc_ctx,
    input  logic             acc_sel,
    input  lm_mode_e         acc_mode,
    output logic [AW-1:0]    acc_addr
);
    localparam int IDX_W = CTX_W + 1;
    localparam int NPTR  = 1 << IDX_W;

    logic [AW-1:0]    ptr_q [NPTR];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] acc_idx;
    logic [AW-1:0]    wr_fold;
    logic             hit;
    logic [AW-1:0]    upd;

    always_comb begin
        wr_idx   = {wr_ctx, wr_sel};
        acc_idx  = {acc_ctx, acc_sel};
        wr_fold  = AW'(lm_fold(32'(wr_val), DEPTH));
        hit      = wr_en && (wr_idx == acc_idx);
        acc_addr = hit ? wr_fold : ptr_q[acc_idx];
        upd      = AW'(lm_step(32'(acc_addr), acc_mode, DEPTH));
    end

    // One register per pointer; an access to it takes priority because
    // its update already starts from the loaded value on a collision.
    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[i] <= '0;
            else if (acc_en && acc_idx == IDX_W'(i))
                ptr_q[i] <= upd;
            else if (wr_en && wr_idx == IDX_W'(i))
                ptr_q[i] <= wr_fold;
        end
    end

    // Checker state: what the previous access did.
    logic             chk_v;
    lm_mode_e         chk_mode;
    logic [IDX_W-1:0] chk_idx;
    logic [AW-1:0]    chk_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v    <= 1'b0;
            chk_mode <= LM_PLAIN;
            chk_idx  <= '0;
            chk_addr <= '0;
        end else begin
            chk_v    <= acc_en;
            chk_mode <= acc_mode;
            chk_idx  <= acc_idx;
            chk_addr <= acc_addr;
        end
    end

    // R2: an access never leaves the memory range
    a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> (32'(acc_addr) < DEPTH));

    // R3: plain and spare modes keep the pointer
    a_r3_plain_keeps: assert property (@(posedge clk) disable iff (rst)
        (chk_v && (chk_mode == LM_PLAIN || chk_mode == LM_SPARE))
            |-> ptr_q[chk_idx] == chk_addr);

    // R4: post-increment wraps at DEPTH-1
    a_r4_post_inc: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_mode == LM_POSTINC)
            |-> ptr_q[chk_idx] == ((chk_addr == AW'(DEPTH - 1)) ? '0 : chk_addr + AW'(1)));

    // R5: post-decrement wraps at 0
    a_r5_post_dec: assert property (@(posedge clk) disable iff (rst)
        (chk_v && chk_mode == LM_POSTDEC)
            |-> ptr_q[chk_idx] == ((chk_addr == '0) ? AW'(DEPTH - 1) : chk_addr - AW'(1)));

endmodule

// File: rtl/lm_array.sv
module lm_array #(
    parameter int DEPTH  = 640,
    parameter int AW     = $clog2(DEPTH),
    parameter int DW     = 32,
    parameter int RD_LAT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
    } stage_t;

    logic [DW-1:0] mem [DEPTH];
    stage_t        stg [RD_LAT];

    always_ff @(posedge clk) begin
        if (en && we)
            mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < RD_LAT; k++)
                stg[k] <= '0;
        end else begin
            stg[0].v <= en && !we;
            if (en && !we)
                stg[0].d <= mem[addr];
            for (int k = 1; k < RD_LAT; k++)
                stg[k] <= stg[k-1];
        end
    end

    assign rd_valid = stg[RD_LAT-1].v;
    assign rd_data  = stg[RD_LAT-1].d;

    // R9: every read moves one stage per cycle, none is lost
    for (genvar k = 1; k < RD_LAT; k++) begin : g_chk
        a_r9_stage_step: assert property (@(posedge clk) disable iff (rst)
            stg[k-1].v |=> stg[k].v);
    end

endmodule

// File: rtl/lm_addr_unit.sv
module lm_addr_unit
    import lmau_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int DEPTH   = 640,
    parameter int DW      = 32,
    parameter int RD_LAT  = 3,
    parameter int AW      = $clog2(DEPTH),
    parameter int CTX_W   = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_wr_en,
    input  logic [CTX_W-1:0] ptr_wr_ctx,
    input  logic             ptr_wr_sel,
    input  logic [AW-1:0]    ptr_wr_val,
    input  logic             acc_en,
    input  logic [CTX_W-1:0] acc_ctx,
    input  logic             acc_sel,
    input  logic [1:0]       acc_mode,
    input  logic             acc_we,
    input  logic [DW-1:0]    acc_wdata,
    output logic [AW-1:0]    acc_addr,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    lm_mode_e mode;
    assign mode = lm_mode_e'(acc_mode);

    lm_ptr_file #(
        .NUM_CTX (NUM_CTX),
        .DEPTH   (DEPTH),
        .AW      (AW),
        .CTX_W   (CTX_W)
    ) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ptr_wr_en),
        .wr_ctx   (ptr_wr_ctx),
        .wr_sel   (ptr_wr_sel),
        .wr_val   (ptr_wr_val),
        .acc_en   (acc_en),
        .acc_ctx  (acc_ctx),
        .acc_sel  (acc_sel),
        .acc_mode (mode),
        .acc_addr (acc_addr)
    );

    lm_array #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .DW     (DW),
        .RD_LAT (RD_LAT)
    ) u_mem (
        .clk      (clk),
        .rst      (rst),
        .en       (acc_en),
        .we       (acc_we),
        .addr     (acc_addr),
        .wdata    (acc_wdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/sim_lm_addr_unit.sv
`timescale 1ns/1ps
module sim_lm_addr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        ptr_wr_en;
    logic [2:0]  ptr_wr_ctx;
    logic        ptr_wr_sel;
    logic [9:0]  ptr_wr_val;
    logic        acc_en;
    logic [2:0]  acc_ctx;
    logic        acc_sel;
    logic [1:0]  acc_mode;
    logic        acc_we;
    logic [31:0] acc_wdata;
    logic [9:0]  acc_addr;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lm_addr_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .ptr_wr_en  (ptr_wr_en),
        .ptr_wr_ctx (ptr_wr_ctx),
        .ptr_wr_sel (ptr_wr_sel),
        .ptr_wr_val (ptr_wr_val),
        .acc_en     (acc_en),
        .acc_ctx    (acc_ctx),
        .acc_sel    (acc_sel),
        .acc_mode   (acc_mode),
        .acc_we     (acc_we),
        .acc_wdata  (acc_wdata),
        .acc_addr   (acc_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] wc;
        logic       ws;
        logic [9:0] wv;
        logic       ae;
        logic [2:0] ac;
        logic       asl;
        logic [1:0] md;
        logic [9:0] ex;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'd0, 1'b0, 10'd5,   1'b0, 3'd0, 1'b0, 2'b00, 10'd0,   4'd2}, // R2 load c0p0=5
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b01, 10'd5,   4'd4}, // R4 inc
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b01, 10'd6,   4'd7}, // R7 back to back
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b10, 10'd7,   4'd5}, // R5 dec
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b00, 10'd6,   4'd3}, // R3 plain
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b11, 10'd6,   4'd3}, // R3 spare code
        '{1'b1, 3'd0, 1'b0, 10'd639, 1'b1, 3'd0, 1'b0, 2'b01, 10'd639, 4'd6}, // R6 load wins
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b00, 10'd0,   4'd4}, // R4 wrap to 0
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b10, 10'd0,   4'd5}, // R5 dec from 0
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd0, 1'b0, 2'b00, 10'd639, 4'd5}, // R5 wrap to 639
        '{1'b1, 3'd3, 1'b1, 10'd700, 1'b0, 3'd0, 1'b0, 2'b00, 10'd0,   4'd2}, // R2 fold 700
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd3, 1'b1, 2'b00, 10'd60,  4'd2}, // R2 folded value
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd3, 1'b0, 2'b00, 10'd0,   4'd2}, // R2 sibling untouched
        '{1'b1, 3'd7, 1'b1, 10'd100, 1'b1, 3'd7, 1'b0, 2'b01, 10'd0,   4'd2}, // R2 load other ptr
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd7, 1'b1, 2'b10, 10'd100, 4'd2}, // R2 loaded
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd7, 1'b0, 2'b00, 10'd1,   4'd4}, // R4 stepped
        '{1'b0, 3'd0, 1'b0, 10'd0,   1'b1, 3'd7, 1'b1, 2'b00, 10'd99,  4'd5}  // R5 stepped
    };

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive(logic we, logic [2:0] wc, logic ws, logic [9:0] wv,
                         logic ae, logic [2:0] ac, logic asl, logic [1:0] md,
                         logic awe, logic [31:0] wd);
        ptr_wr_en  = we;
        ptr_wr_ctx = wc;
        ptr_wr_sel = ws;
        ptr_wr_val = wv;
        acc_en     = ae;
        acc_ctx    = ac;
        acc_sel    = asl;
        acc_mode   = md;
        acc_we     = awe;
        acc_wdata  = wd;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd5, 1'b1, 2'b00, 1'b0, 32'd0);
        #0.5;
        check("R1 ptr c5p1", 32'(acc_addr), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        @(negedge clk);
        idle();
        repeat (4) @(negedge clk);

        // Table walk: pointer loads and addressing modes
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].we, TBL[i].wc, TBL[i].ws, TBL[i].wv,
                  TBL[i].ae, TBL[i].ac, TBL[i].asl, TBL[i].md, 1'b0, 32'd0);
            #0.5;
            if (TBL[i].ae)
                check($sformatf("R%0d row %0d", TBL[i].rq, i),
                      32'(acc_addr), 32'(TBL[i].ex));
            @(negedge clk);
        end
        idle();
        repeat (5) @(negedge clk);

        // R9: three writes, then three back-to-back reads
        drive(1'b1, 3'd1, 1'b0, 10'd10, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd1, 1'b0, 2'b01, 1'b1, 32'hA5A5_0001);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd1, 1'b0, 2'b01, 1'b1, 32'hA5A5_0002);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd1, 1'b0, 2'b01, 1'b1, 32'hA5A5_0003);
        @(negedge clk);
        drive(1'b1, 3'd1, 1'b0, 10'd10, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd1, 1'b0, 2'b01, 1'b0, 32'd0);
        #0.5;
        check("R9 read addr", 32'(acc_addr), 32'd10);
        @(negedge clk);
        check("R9 not early 1", 32'(rd_valid), 32'd0);
        @(negedge clk);
        check("R9 not early 2", 32'(rd_valid), 32'd0);
        @(negedge clk);
        idle();
        check("R9 valid 0", 32'(rd_valid), 32'd1);
        check("R9 data 0", rd_data, 32'hA5A5_0001);
        @(negedge clk);
        check("R9 valid 1", 32'(rd_valid), 32'd1);
        check("R9 data 1", rd_data, 32'hA5A5_0002);
        @(negedge clk);
        check("R9 valid 2", 32'(rd_valid), 32'd1);
        check("R9 data 2", rd_data, 32'hA5A5_0003);
        @(negedge clk);
        check("R9 drained", 32'(rd_valid), 32'd0);

        // R8: write then read the same word in the next cycle
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd2, 1'b1, 2'b00, 1'b1, 32'hDEAD_BEEF);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd2, 1'b1, 2'b00, 1'b0, 32'd0);
        @(negedge clk);
        idle();
        repeat (2) @(negedge clk);
        check("R8 valid", 32'(rd_valid), 32'd1);
        check("R8 data", rd_data, 32'hDEAD_BEEF);
        repeat (3) @(negedge clk);

        // R10: idle cycle with junk controls must not step, write or read
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd0, 1'b0, 2'b00, 1'b1, 32'h1111_2222);
        #0.5;
        check("R10 setup addr", 32'(acc_addr), 32'd639);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b0, 3'd0, 1'b0, 2'b01, 1'b1, 32'h3333_4444);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b0, 3'd0, 1'b0, 2'b10, 1'b0, 32'h0);
        @(negedge clk);
        drive(1'b0, 3'd0, 1'b0, 10'd0, 1'b1, 3'd0, 1'b0, 2'b00, 1'b0, 32'd0);
        #0.5;
        check("R10 ptr held", 32'(acc_addr), 32'd639);
        @(negedge clk);
        idle();
        check("R10 no read from idle", 32'(rd_valid), 32'd0);
        @(negedge clk);
        check("R10 no read from idle 2", 32'(rd_valid), 32'd0);
        @(negedge clk);
        check("R10 valid", 32'(rd_valid), 32'd1);
        check("R10 word kept", rd_data, 32'h1111_2222);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule